// File: doc/BRIEF.md
# UART receiver with error-tagged FIFO

This block is the receive half of an asynchronous serial port. It oversamples the incoming line at sixteen times the bit rate and assembles characters of five to eight data bits, with an optional parity bit and one or two stop bits. Each finished character goes into a small receive queue together with three error flags: framing, parity and overrun. Because the flags travel with the character, one read of the data word returns the character and the errors that belong to that character alone.

Software-facing logic sets the line format with a few static control inputs: word length, parity enable, parity sense, two stop bits, queue enable and the bit-rate divisor. It drains the queue by watching an empty flag and pulsing a read strobe. The word at the queue head is always on the read-data output. The strobe removes that word.

When the queue is turned off, the receiver keeps a single holding entry. Any character that arrives while the queue or the holding entry is full is dropped, and the overrun flag is set on the entry that was stored last.

Top module: `uart_rx_errq`

## Requirements
- R1: `rd_data_o` always shows the oldest stored entry. Bits 7:0 hold the character, bit 8 the framing error, bit 9 the parity error and bit 10 the overrun flag. A one-cycle `rd_i` pulse while `rx_empty_o` is low removes that entry.
- R2: `wlen_i` selects the data width: 2'b00 gives 5 bits, 2'b01 gives 6, 2'b10 gives 7 and 2'b11 gives 8. Data arrives least significant bit first, and data bits above the selected width read as 0.
- R3: When `par_en_i` is 1, one parity bit follows the data bits. `par_even_i`=1 expects an even count of ones over data and parity, and 0 expects an odd count. A mismatch sets bit 9. When `par_en_i` is 0, no parity bit is expected and bit 9 is always 0.
- R4: One bit lasts 16*(`div_i`+1) clock cycles. A start bit is accepted only if the line is still low at the 8th sample after the falling edge, so a low pulse shorter than half a bit stores nothing. Data bits are sampled at their centres.
- R5: A stop bit sampled as 0 sets bit 8, and the character is still stored. With `two_stop_i`=1 the receiver samples two stop bits, and either one being 0 sets bit 8.
- R6: With `fifo_en_i`=1 the queue holds 16 entries in arrival order. `rx_empty_o` is 1 exactly when no entry is held. `rd_i` while the queue is empty has no effect.
- R7: A character that completes while the queue is full is dropped, and bit 10 is set on the most recently stored entry. The other entries are unchanged.
- R8: With `fifo_en_i`=0 the receiver holds at most one entry. A second character that arrives before that entry is read is dropped, and bit 10 is set on the held entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Serial receive line, idle high |
| div_i | input | 12 | Bit-rate divisor; bit time is 16*(div_i+1) clocks |
| wlen_i | input | 2 | Word length code |
| par_en_i | input | 1 | Parity bit present and checked |
| par_even_i | input | 1 | 1 = even parity, 0 = odd parity |
| two_stop_i | input | 1 | Expect two stop bits |
| fifo_en_i | input | 1 | 1 = 16-entry queue, 0 = single holding entry |
| rd_i | input | 1 | Read strobe; removes the head entry |
| rd_data_o | output | 11 | Head entry: character and error flags |
| rx_empty_o | output | 1 | No entry held |

## Verification
Directed frames cover each word length with all data bits set, so that masking of the upper bits shows up, and even and odd parity with correct and with corrupted parity bits. They also cover a zero stop bit in one-stop and two-stop framing, a runt low pulse, and a slower divisor. Between them these separate width decoding, parity sense, stop-bit handling and start validation. Random frames then vary data and format together and catch bit-order or alignment slips that one fixed pattern could hide. Sixteen frames followed by a seventeenth test the full-queue drop and the place the overrun flag lands, and two unread frames with the queue off check the single-entry limit.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef struct packed {
    logic       ovr;
    logic       perr;
    logic       ferr;
    logic [7:0] data;
  } rx_word_t;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP1, S_STOP2
  } rx_state_e;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '1;
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/uart_rx_baud.sv
module uart_rx_baud #(
  parameter int DIV_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  // >= so that lowering the divisor never runs the counter around
  assign tick_o = (cnt_q >= div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/uart_rx_deser.sv
module uart_rx_deser
  import uart_rx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       rx_i,
  input  logic [1:0] wlen_i,
  input  logic       par_en_i,
  input  logic       par_even_i,
  input  logic       two_stop_i,
  output logic       vld_o,
  output rx_word_t   word_o
);
  rx_state_e  state_q;
  logic [3:0] tcnt_q;
  logic [2:0] bcnt_q;
  logic [7:0] sh_q;
  logic       pbit_q, ferr_q, vld_q;
  rx_word_t   word_q;
  logic [7:0] aligned;
  logic       perr, last_bit, mid;

  always_comb begin
    aligned  = sh_q >> (2'd3 - wlen_i);
    perr     = par_en_i & (^aligned ^ pbit_q ^ ~par_even_i);
    last_bit = (bcnt_q == (3'd4 + {1'b0, wlen_i}));
    mid      = (tcnt_q == 4'd15);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      tcnt_q  <= '0;
      bcnt_q  <= '0;
      sh_q    <= '0;
      pbit_q  <= 1'b0;
      ferr_q  <= 1'b0;
      vld_q   <= 1'b0;
      word_q  <= '0;
    end else begin
      vld_q <= 1'b0;
      if (tick_i) begin
        tcnt_q <= tcnt_q + 1'b1;
        unique case (state_q)
          S_IDLE: begin
            tcnt_q <= '0;
            if (!rx_i) state_q <= S_START;
          end
          S_START: if (tcnt_q == 4'd7) begin
            tcnt_q  <= '0;
            bcnt_q  <= '0;
            state_q <= rx_i ? S_IDLE : S_DATA;
          end
          S_DATA: if (mid) begin
            sh_q   <= {rx_i, sh_q[7:1]};
            bcnt_q <= bcnt_q + 1'b1;
            if (last_bit) state_q <= par_en_i ? S_PAR : S_STOP1;
          end
          S_PAR: if (mid) begin
            pbit_q  <= rx_i;
            state_q <= S_STOP1;
          end
          S_STOP1: if (mid) begin
            ferr_q <= !rx_i;
            if (two_stop_i) begin
              state_q <= S_STOP2;
            end else begin
              state_q <= S_IDLE;
              vld_q   <= 1'b1;
              word_q  <= '{ovr: 1'b0, perr: perr, ferr: !rx_i, data: aligned};
            end
          end
          S_STOP2: if (mid) begin
            state_q <= S_IDLE;
            vld_q   <= 1'b1;
            word_q  <= '{ovr: 1'b0, perr: perr, ferr: ferr_q | !rx_i, data: aligned};
          end
          default: state_q <= S_IDLE;
        endcase
      end
    end
  end

  assign vld_o  = vld_q;
  assign word_o = word_q;
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  rx_word_t      word_i,
  input  logic          pop_i,
  input  logic          single_i,
  output rx_word_t      head_o,
  output logic          empty_o,
  output logic [CW-1:0] cnt_o
);
  rx_word_t        mem_q [DEPTH];
  logic [AW-1:0]   wptr_q, rptr_q;
  logic [CW-1:0]   cnt_q;
  logic            full, pop_eff, accept, ovr_set;

  always_comb begin
    empty_o = (cnt_q == '0);
    full    = single_i ? !empty_o : (cnt_q == CW'(DEPTH));
    pop_eff = pop_i & !empty_o;
    accept  = push_i & (!full | pop_eff);
    ovr_set = push_i & full & !pop_eff;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (accept) begin
        mem_q[wptr_q] <= word_i;
        wptr_q        <= wptr_q + 1'b1;
      end
      if (ovr_set) mem_q[wptr_q - 1'b1].ovr <= 1'b1;
      if (pop_eff) rptr_q <= rptr_q + 1'b1;
      cnt_q <= cnt_q + CW'(accept) - CW'(pop_eff);
    end
  end

  assign head_o = mem_q[rptr_q];
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/uart_rx_errq.sv
module uart_rx_errq
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DIV_W = 12,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [1:0]       wlen_i,
  input  logic             par_en_i,
  input  logic             par_even_i,
  input  logic             two_stop_i,
  input  logic             fifo_en_i,
  input  logic             rd_i,
  output logic [10:0]      rd_data_o,
  output logic             rx_empty_o
);
  logic          rx_s, tick, push_w;
  rx_word_t      push_ent_w, head;
  logic [CW-1:0] fifo_cnt_w;

  uart_rx_sync #(.STAGES(2)) sync_i (
    .clk_i, .rst_ni, .d_i(rx_i), .q_o(rx_s)
  );

  uart_rx_baud #(.DIV_W(DIV_W)) baud_i (
    .clk_i, .rst_ni, .div_i, .tick_o(tick)
  );

  uart_rx_deser deser_i (
    .clk_i, .rst_ni, .tick_i(tick), .rx_i(rx_s), .wlen_i, .par_en_i,
    .par_even_i, .two_stop_i, .vld_o(push_w), .word_o(push_ent_w)
  );

  uart_rx_fifo #(.DEPTH(DEPTH)) fifo_i (
    .clk_i, .rst_ni, .push_i(push_w), .word_i(push_ent_w), .pop_i(rd_i),
    .single_i(!fifo_en_i), .head_o(head), .empty_o(rx_empty_o),
    .cnt_o(fifo_cnt_w)
  );

  assign rd_data_o = head;
endmodule

// File: rtl/uart_rx_errq_chk.sv
module uart_rx_errq_chk
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rd_i,
  input logic          rx_empty_o,
  input logic          fifo_en_i,
  input logic          par_en_i,
  input logic [1:0]    wlen_i,
  input logic          push_w,
  input rx_word_t      push_ent_w,
  input logic [CW-1:0] fifo_cnt_w
);
  a_r1_push_visible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_w |=> !rx_empty_o);

  a_r2_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_w |-> ((push_ent_w.data >> (4'd5 + {2'b0, wlen_i})) == 8'd0));

  a_r3_no_perr_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_w && !par_en_i) |-> !push_ent_w.perr);

  a_r6_empty_read_noop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_empty_o && rd_i && !push_w) |=> rx_empty_o);

  a_r6_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_cnt_w <= CW'(DEPTH));

  a_r7_fresh_no_ovr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_w |-> !push_ent_w.ovr);

  a_r8_single_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_en_i |-> fifo_cnt_w <= CW'(1));
endmodule

bind uart_rx_errq uart_rx_errq_chk #(.DEPTH(DEPTH)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .rd_i(rd_i), .rx_empty_o(rx_empty_o),
  .fifo_en_i(fifo_en_i), .par_en_i(par_en_i), .wlen_i(wlen_i),
  .push_w(push_w), .push_ent_w(push_ent_w), .fifo_cnt_w(fifo_cnt_w)
);

// File: tb/uart_rx_errq_tb_top.sv
module uart_rx_errq_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rx_i = 1'b1;
  logic [11:0] div_i = 12'd1;
  logic [1:0]  wlen_i = 2'b11;
  logic        par_en_i = 1'b0, par_even_i = 1'b0, two_stop_i = 1'b0;
  logic        fifo_en_i = 1'b1, rd_i = 1'b0;
  logic [10:0] rd_data_o;
  logic        rx_empty_o;

  int checks = 0, fails = 0, bt = 32;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  uart_rx_errq dut_i (.*);

  function automatic logic [7:0] mask_of(input logic [1:0] wl);
    return 8'hFF >> (2'd3 - wl);
  endfunction

  function automatic logic [10:0] exp_word(input logic [7:0] d, input logic [1:0] wl,
      input bit pen, input bit bad_par, input bit bad_stop);
    return {1'b0, pen & bad_par, bad_stop, d & mask_of(wl)};
  endfunction

  task automatic drive_bit(input logic v);
    rx_i = v;
    repeat (bt) @(negedge clk_i);
  endtask

  task automatic send_char(input logic [7:0] d, input bit bad_par, input bit bad_stop);
    logic [7:0] dm;
    logic p;
    dm = d & mask_of(wlen_i);
    p = (^dm) ^ ~par_even_i ^ bad_par;
    drive_bit(1'b0);
    for (int i = 0; i < 5 + int'(wlen_i); i++) drive_bit(dm[i]);
    if (par_en_i) drive_bit(p);
    drive_bit(!bad_stop);
    if (two_stop_i) drive_bit(1'b1);
    drive_bit(1'b1);
  endtask

  task automatic check(input bit ok, input string req, input logic [10:0] act,
      input logic [10:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic read_check(input logic [10:0] exp, input string req);
    check(!rx_empty_o, req, {10'd0, rx_empty_o}, 11'd0);
    check(rd_data_o == exp, req, rd_data_o, exp);
    rd_i = 1'b1;
    @(negedge clk_i);
    rd_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic empty_check(input string req);
    check(rx_empty_o == 1'b1, req, {10'd0, rx_empty_o}, 11'd1);
  endtask

  task automatic one(input logic [7:0] d, input bit bp, input bit bs, input string req);
    send_char(d, bp, bs);
    read_check(exp_word(d, wlen_i, par_en_i, bp, bs), req);
    empty_check(req);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    empty_check("R6 reset empty");

    // R1 R2 basic 8N1
    one(8'hA5, 0, 0, "R1 8N1 A5");
    // R2 each width with all ones, upper bits must read zero
    for (int w = 0; w < 4; w++) begin
      wlen_i = w[1:0];
      one(8'hFF, 0, 0, "R2 width mask");
      one(8'h5A, 0, 0, "R2 width lsb first");
    end
    wlen_i = 2'b11;
    // R3 parity senses
    par_en_i = 1'b1; par_even_i = 1'b1;
    one(8'h37, 0, 0, "R3 even ok");
    one(8'h37, 1, 0, "R3 even bad");
    par_even_i = 1'b0;
    one(8'hC1, 0, 0, "R3 odd ok");
    one(8'hC1, 1, 0, "R3 odd bad");
    par_en_i = 1'b0;
    // R5 framing
    one(8'h3C, 0, 1, "R5 stop zero");
    two_stop_i = 1'b1;
    one(8'h81, 0, 0, "R5 two stop ok");
    one(8'h81, 0, 1, "R5 two stop bad");
    two_stop_i = 1'b0;
    // R4 runt pulse shorter than half bit
    rx_i = 1'b0;
    repeat (bt / 2 - 4) @(negedge clk_i);
    rx_i = 1'b1;
    repeat (3 * bt) @(negedge clk_i);
    empty_check("R4 runt ignored");
    // R4 slower divisor
    div_i = 12'd3; bt = 64;
    one(8'h96, 0, 0, "R4 divisor 3");
    div_i = 12'd1; bt = 32;
    // R6 read on empty has no effect
    rd_i = 1'b1; @(negedge clk_i); rd_i = 1'b0; @(negedge clk_i);
    empty_check("R6 empty read");
    one(8'h42, 0, 0, "R6 after empty read");

    // random formats
    for (int n = 0; n < 24; n++) begin
      logic [7:0] d;
      bit bp, bs;
      d = 8'($urandom);
      wlen_i = 2'($urandom);
      par_en_i = 1'($urandom);
      par_even_i = 1'($urandom);
      two_stop_i = 1'($urandom);
      bp = ($urandom % 4) == 0;
      bs = ($urandom % 4) == 0;
      one(d, bp, bs, "R1 R2 R3 R5 random");
    end
    wlen_i = 2'b11; par_en_i = 1'b0; two_stop_i = 1'b0;

    // R6 R7 fill queue then overrun
    begin
      logic [7:0] q [16];
      for (int n = 0; n < 16; n++) begin
        q[n] = 8'($urandom);
        send_char(q[n], 0, 0);
      end
      send_char(8'hEE, 0, 0);
      for (int n = 0; n < 15; n++) read_check({3'b000, q[n]}, "R6 order");
      read_check({3'b100, q[15]}, "R7 overrun tag");
      empty_check("R7 new dropped");
    end

    // R8 bypass
    fifo_en_i = 1'b0;
    send_char(8'h11, 0, 0);
    send_char(8'h22, 0, 0);
    read_check({3'b100, 8'h11}, "R8 single overrun");
    empty_check("R8 single dropped");
    one(8'h33, 0, 0, "R8 single ok");
    fifo_en_i = 1'b1;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule